// File: doc/BRIEF.md
# Fractional Feedback Divider Chain

This block sits in the feedback path of a digital PLL. A clock at the post-divider rate runs through an integer prescaler and then through a fractional divider. The divider issues one single-cycle pulse per sample period of the downstream phase detector. The prescaler divides by a programmable value from 2 to 17. The fractional stage divides the prescaler ticks by an average ratio of INT + NUM/DEN. It does this with a first-order modulus-DEN accumulator: each time the accumulator overflows, one count period is stretched by a single tick.

Both outputs are clock enables in the input clock domain, never derived clocks. The divisor fields are picked up only when a period is loaded, so a configuration change never shortens the period already in progress. Degenerate fractions fall back to plain integer division.

Top module: `fbdiv_chain`

## Requirements
- R1: While rst_ni is low, pre_en_o and div_pulse_o are both 0.
- R2: For pre_div_i in 2..17, pre_en_o is high for one clock cycle once every pre_div_i clock cycles.
- R3: pre_div_i is 5 bits wide. A value below 2 divides as 2, and a value above 17 divides as 17.
- R4: div_pulse_o is never high for two cycles in a row. It is only high in the cycle right after a cycle in which pre_en_o was high.
- R5: When num_i is 0, den_i is 0, or num_i >= den_i, the fraction is disabled. Every interval between div_pulse_o pulses is then INT prescaler ticks.
- R6: The fractional period sequence works as follows. The accumulator is 0 after reset. At each period load, the sum acc+num_i is formed. If the sum is >= den_i, DEN is subtracted and the period is INT+1 ticks; otherwise the period is INT ticks. The first load after reset belongs to the interval that ends at the first pulse.
- R7: Any DEN consecutive pulse intervals add up to INT*DEN + NUM prescaler ticks.
- R8: int_i, num_i and den_i are sampled only when a period is loaded, which happens on the same edge that raises a div_pulse_o pulse. A change made after a pulse first takes effect on the interval after the next pulse.
- R9: int_i = 0 divides as 1.
- R10: The full 40-bit widths of num_i and den_i are used with no truncation. For example, num_i = 2^39 and den_i = 2^40-1 follow the R6 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Post-divider input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pre_div_i | input | 5 | Prescaler divide value (2..17 effective) |
| int_i | input | 30 | Integer part of fractional divide |
| num_i | input | 40 | Fraction numerator |
| den_i | input | 40 | Fraction denominator (modulus) |
| pre_en_o | output | 1 | Prescaler clock enable, one cycle wide |
| div_pulse_o | output | 1 | Divided sample pulse, one cycle wide |

## Verification
Pure integer settings (zero numerator, zero denominator, numerator not below denominator) must give identical intervals. This separates a correctly gated accumulator from one that leaks carries. Small fractions such as 1/3 and 3/7 pin down exactly where the stretched periods fall and check the average over a full modulus. A near-full-scale 40-bit fraction exposes any truncated adder or compare. Out-of-range prescaler codes, a zero integer part, and a mid-run integer change test the clamping and confirm that sampling happens only at the boundary.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int unsigned PRE_W_DEF   = 5;
  localparam int unsigned PRE_MIN_DEF = 2;
  localparam int unsigned PRE_MAX_DEF = 17;
  localparam int unsigned INT_W_DEF   = 30;
  localparam int unsigned FRAC_W_DEF  = 40;
endpackage

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler #(
  parameter int unsigned PRE_W   = fbdiv_pkg::PRE_W_DEF,
  parameter int unsigned PRE_MIN = fbdiv_pkg::PRE_MIN_DEF,
  parameter int unsigned PRE_MAX = fbdiv_pkg::PRE_MAX_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] pre_div_i,
  output logic             en_o
);
  localparam logic [PRE_W-1:0] MIN_V = PRE_W'(PRE_MIN);
  localparam logic [PRE_W-1:0] MAX_V = PRE_W'(PRE_MAX);
  localparam logic [PRE_W-1:0] ONE   = PRE_W'(1);

  logic [PRE_W-1:0] cnt_q, pre_eff;
  logic             en_q;

  always_comb begin
    if (pre_div_i < MIN_V)      pre_eff = MIN_V;
    else if (pre_div_i > MAX_V) pre_eff = MAX_V;
    else                        pre_eff = pre_div_i;
  end

  // en_q follows cnt_q==0 except in the first cycle out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q  <= (cnt_q == ONE);
      cnt_q <= (cnt_q == '0) ? pre_eff - ONE : cnt_q - ONE;
    end
  end

  assign en_o = en_q;

  p_pre_en_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> !en_q);
  p_pre_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_V - ONE);
endmodule

// File: rtl/fbdiv_frac_acc.sv
module fbdiv_frac_acc #(
  parameter int unsigned FRAC_W = fbdiv_pkg::FRAC_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] num_i,
  input  logic [FRAC_W-1:0] den_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum, rem, den_x;
  logic              frac_en, over;

  always_comb begin
    frac_en = (num_i != '0) && (den_i != '0) && (num_i < den_i);
    den_x   = {1'b0, den_i};
    sum     = {1'b0, acc_q} + {1'b0, num_i};
    over    = frac_en && (sum >= den_x);
    rem     = over ? sum - den_x : sum;
  end

  assign carry_o = over;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (step_i) begin
      if (!frac_en)        acc_q <= '0;
      else if (rem >= den_x) acc_q <= '0;  // stale residue after a modulus change
      else                 acc_q <= rem[FRAC_W-1:0];
    end
  end

  p_acc_below_den_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && frac_en) |=> (acc_q < $past(den_i)));
  p_acc_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !frac_en) |=> (acc_q == '0));
endmodule

// File: rtl/fbdiv_period_ctr.sv
module fbdiv_period_ctr #(
  parameter int unsigned CNT_W = fbdiv_pkg::INT_W_DEF + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             load_o,
  output logic             pulse_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q;

  // cnt_q==0 only right after reset: first tick loads without a pulse
  assign load_o = tick_i && (cnt_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= tick_i && (cnt_q == ONE);
      if (tick_i) cnt_q <= (cnt_q <= ONE) ? period_i : cnt_q - ONE;
    end
  end

  assign pulse_o = pulse_q;

  p_pulse_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  p_period_nonzero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (period_i != '0));
endmodule

// File: rtl/fbdiv_chain.sv
module fbdiv_chain #(
  parameter int unsigned PRE_W   = fbdiv_pkg::PRE_W_DEF,
  parameter int unsigned PRE_MIN = fbdiv_pkg::PRE_MIN_DEF,
  parameter int unsigned PRE_MAX = fbdiv_pkg::PRE_MAX_DEF,
  parameter int unsigned INT_W   = fbdiv_pkg::INT_W_DEF,
  parameter int unsigned FRAC_W  = fbdiv_pkg::FRAC_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRE_W-1:0]  pre_div_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] num_i,
  input  logic [FRAC_W-1:0] den_i,
  output logic              pre_en_o,
  output logic              div_pulse_o
);
  localparam int unsigned CNT_W = INT_W + 1;

  logic             tick, load, carry;
  logic [INT_W-1:0] int_eff;
  logic [CNT_W-1:0] period;

  fbdiv_prescaler #(.PRE_W(PRE_W), .PRE_MIN(PRE_MIN), .PRE_MAX(PRE_MAX)) i_pre (
    .clk_i, .rst_ni, .pre_div_i, .en_o(tick)
  );

  fbdiv_frac_acc #(.FRAC_W(FRAC_W)) i_acc (
    .clk_i, .rst_ni, .step_i(load), .num_i, .den_i, .carry_o(carry)
  );

  always_comb begin
    int_eff = (int_i == '0) ? INT_W'(1) : int_i;
    period  = CNT_W'(int_eff) + CNT_W'(carry);
  end

  fbdiv_period_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk_i, .rst_ni, .tick_i(tick), .period_i(period), .load_o(load), .pulse_o(div_pulse_o)
  );

  assign pre_en_o = tick;

  p_pulse_after_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |-> $past(pre_en_o));
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!pre_en_o && !div_pulse_o));
endmodule

// File: tb/test_fbdiv_chain.sv
`timescale 1ns/1ps
module test_fbdiv_chain;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  pre_div = 5'd2;
  logic [29:0] int_v = 30'd1;
  logic [39:0] num_v = '0;
  logic [39:0] den_v = '0;
  logic        pre_en_o, div_pulse_o;

  int checks = 0, fails = 0, cyc = 0;
  int tdiv[64];
  int tpre[64];
  int np = 0, npre = 0, wbad = 0, obad = 0;
  bit rec_en = 0, prev_div = 0, prev_pre = 0;
  int per[64];

  always #2.5 clk = ~clk;

  fbdiv_chain i_fbdiv_chain (
    .clk_i(clk), .rst_ni(rst_n), .pre_div_i(pre_div), .int_i(int_v),
    .num_i(num_v), .den_i(den_v), .pre_en_o(pre_en_o), .div_pulse_o(div_pulse_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog R1..: act cyc=%0d exp below 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rec_en) begin
      if (pre_en_o) begin
        if (npre < 64) tpre[npre] = cyc;
        npre = npre + 1;
      end
      if (div_pulse_o) begin
        if (np < 64) tdiv[np] = cyc;
        np = np + 1;
        if (prev_div) wbad = wbad + 1;
        if (!prev_pre) obad = obad + 1;
      end
    end
    prev_div = div_pulse_o;
    prev_pre = pre_en_o;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [4:0] p, input logic [29:0] iv,
                       input logic [39:0] nm, input logic [39:0] dn);
    @(negedge clk);
    rec_en = 0;
    rst_n = 0;
    pre_div = p; int_v = iv; num_v = nm; den_v = dn;
    repeat (3) @(negedge clk);
    chk(!pre_en_o && !div_pulse_o, "R1 outputs in reset", {pre_en_o, div_pulse_o}, 0);
    np = 0; npre = 0; wbad = 0; obad = 0;
    rec_en = 1;
    rst_n = 1;
  endtask

  task automatic wait_pulses(input int n);
    int guard = 0;
    while (np < n && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(np >= n, "R4 pulses arrive", np, n);
  endtask

  // expected period sequence from the accumulator rule
  task automatic model(input logic [29:0] iv, input logic [39:0] nm,
                       input logic [39:0] dn, input int n);
    logic [40:0] acc, s;
    longint ie;
    bit en;
    acc = '0;
    ie = (iv == 0) ? 1 : longint'(iv);
    en = (nm != 0) && (dn != 0) && (nm < dn);
    for (int k = 0; k < n; k++) begin
      if (!en) per[k] = int'(ie);
      else begin
        s = acc + {1'b0, nm};
        if (s >= {1'b0, dn}) begin
          acc = s - {1'b0, dn};
          per[k] = int'(ie) + 1;
        end else begin
          acc = s;
          per[k] = int'(ie);
        end
      end
    end
  endtask

  task automatic run_case(input string req, input logic [4:0] p, input int p_exp,
                          input logic [29:0] iv, input logic [39:0] nm,
                          input logic [39:0] dn, input int n);
    start(p, iv, nm, dn);
    wait_pulses(n);
    model(iv, nm, dn, n);
    for (int j = 0; j + 1 < n; j++)
      chk(tdiv[j+1] - tdiv[j] == per[j+1] * p_exp, req, tdiv[j+1] - tdiv[j], per[j+1] * p_exp);
    for (int j = 0; j + 1 < npre && j < 8; j++)
      chk(tpre[j+1] - tpre[j] == p_exp, "R2 prescaler spacing", tpre[j+1] - tpre[j], p_exp);
    chk(wbad == 0, "R4 pulse width", wbad, 0);
    chk(obad == 0, "R4 pulse follows tick", obad, 0);
  endtask

  task automatic t_prescaler();
    run_case("R2 pre=17", 5'd17, 17, 30'd1, 40'd0, 40'd0, 4);
    run_case("R2 pre=5", 5'd5, 5, 30'd3, 40'd0, 40'd0, 4);
  endtask

  task automatic t_clamp();
    run_case("R3 pre=0 as 2", 5'd0, 2, 30'd2, 40'd0, 40'd0, 4);
    run_case("R3 pre=31 as 17", 5'd31, 17, 30'd1, 40'd0, 40'd0, 4);
  endtask

  task automatic t_integer();
    run_case("R5 num=0", 5'd3, 3, 30'd6, 40'd0, 40'd5, 5);
    run_case("R5 num>=den", 5'd2, 2, 30'd3, 40'd5, 40'd5, 5);
    run_case("R5 den=0", 5'd2, 2, 30'd4, 40'd9, 40'd0, 5);
  endtask

  task automatic t_fraction();
    run_case("R6 1/3", 5'd2, 2, 30'd3, 40'd1, 40'd3, 8);
    run_case("R6 2/5", 5'd4, 4, 30'd2, 40'd2, 40'd5, 8);
  endtask

  task automatic t_average();
    int tot;
    run_case("R7 3/7 seq", 5'd3, 3, 30'd5, 40'd3, 40'd7, 10);
    tot = tdiv[8] - tdiv[1];
    chk(tot == (5 * 7 + 3) * 3, "R7 sum over DEN intervals", tot, (5 * 7 + 3) * 3);
  endtask

  task automatic t_boundary();
    start(5'd2, 30'd4, 40'd0, 40'd0);
    wait_pulses(2);
    int_v = 30'd7;
    wait_pulses(5);
    chk(tdiv[2] - tdiv[1] == 8, "R8 old INT kept", tdiv[2] - tdiv[1], 8);
    chk(tdiv[3] - tdiv[2] == 14, "R8 new INT applied", tdiv[3] - tdiv[2], 14);
    chk(tdiv[4] - tdiv[3] == 14, "R8 new INT stays", tdiv[4] - tdiv[3], 14);
  endtask

  task automatic t_int_zero();
    run_case("R9 int=0 as 1", 5'd3, 3, 30'd0, 40'd0, 40'd0, 5);
  endtask

  task automatic t_wide();
    run_case("R10 40-bit fraction", 5'd2, 2, 30'd2, 40'h80_0000_0000, 40'hFF_FFFF_FFFF, 10);
  endtask

  initial begin
    t_prescaler();
    t_clamp();
    t_integer();
    t_fraction();
    t_average();
    t_boundary();
    t_int_zero();
    t_wide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule